// File: doc/BRIEF.md
# Compare/Capture Timer Channel with Rule-Driven PWM Level

This block is one up-counting timer channel with a compare register, a power-of-two prescaler and a single PWM output. Configuration arrives as plain level inputs and single-cycle strobes from the surrounding register file. The strobes cover start, stop, counter load, compare load and flag clear. The counter can advance on every system clock, on each rising or falling edge of an asynchronous trigger pin, or on each pulse of a synchronous event line. The prescaler divides whichever source is selected.

In compare mode, a count tick that finds the counter equal to the compare register wraps the counter to zero and raises the match flag. At the same moment the output level is updated by a programmable match rule. Starting and stopping the channel each apply their own level rule. In capture mode, a rising trigger edge copies the counter into the compare register instead. A counter wrapping from all ones to zero raises the overflow flag. Each flag has an interrupt enable that feeds one interrupt line.

Top module: `pwm_timer_ch`

## Requirements
- R1: After reset: `count` = 0, `compare` = all ones, `flags` = 0, `irq` = 0, `pwm_out` = 0 and `running` = 0.
- R2: A `start_i` pulse sets `running` and a `stop_i` pulse clears it, with stop winning when both are set. While stopped, the counter holds its value.
- R3: Each count tick adds one to the counter. In compare mode, a tick with `count == compare` clears the counter and sets `flags[0]`. A tick at 0xFFFF that is not such a match wraps the counter to 0 and sets `flags[1]`. A match on 0xFFFF sets only `flags[0]`.
- R4: `div_code` n (0..10) makes one count tick per 2^n source ticks. Codes 11..15 act as 10. Start clears the prescaler, so with n = 3 the first count comes on the 8th clock after the start edge.
- R5: `src_sel` picks the source: 0 is every clock, 1 is each rising edge of `trig_in`, 2 is each falling edge of `trig_in`, and 3 is each clock with `event_in` high. Edges of `trig_in` take effect three clocks after the pin changes.
- R6: `rule_start` and `rule_stop` set the level on start and on stop: 0 means low, 1 means high, 2 or 3 means keep. Stop wins over start, and both win over a match.
- R7: `rule_match` sets the level on a compare match: 0 means low, 1 means high, 2 means keep, 3 means invert.
- R8: `pwm_out` follows the level one clock later when `pwm_en` is 1, and is 0 otherwise. The level is kept while the output is disabled.
- R9: Writing 1 to `flag_clr[i]` clears `flags[i]`. A new set in the same clock wins over the clear.
- R10: `irq` is 1 when a flag is set whose bit in `irq_en` was set on the previous clock. It is registered and aligned with `flags`.
- R11: In capture mode (`capture_mode` = 1), a rising `trig_in` edge seen while running copies the counter into `compare` and sets `flags[0]`. The counter is not cleared and the level is not changed.
- R12: `cnt_wr` loads `wdata` into the counter over any tick, and suppresses that cycle's match and overflow. `cmp_wr` loads `wdata` into `compare` over a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Count source select |
| div_code | input | DIV_CODE_W | Prescaler code |
| capture_mode | input | 1 | 0 compare output, 1 input capture |
| rule_start | input | 2 | Level rule applied on start |
| rule_stop | input | 2 | Level rule applied on stop |
| rule_match | input | 2 | Level rule applied on compare match |
| pwm_en | input | 1 | PWM output enable |
| start_i | input | 1 | Start strobe |
| stop_i | input | 1 | Stop strobe |
| cnt_wr | input | 1 | Counter load strobe |
| cmp_wr | input | 1 | Compare load strobe |
| wdata | input | CNT_W | Load value for counter or compare |
| flag_clr | input | 2 | Flag clear strobes (bit0 match, bit1 overflow) |
| irq_en | input | 2 | Interrupt enables per flag |
| trig_in | input | 1 | Asynchronous trigger pin |
| event_in | input | 1 | Synchronous event pulse |
| running | output | 1 | Channel is counting |
| count | output | CNT_W | Counter value |
| compare | output | CNT_W | Compare/capture register |
| flags | output | 2 | bit0 match/capture, bit1 overflow |
| irq | output | 1 | Interrupt request |
| pwm_out | output | 1 | PWM output |

## Verification
The bench builds the block with its defaults: a 16-bit counter, a 4-bit prescaler code with a ceiling of 10, and two synchronizer stages. Preloading the counter through `cnt_wr` brings the 0xFFFF wrap and the match-at-0xFFFF case within a few clocks. The ceiling of 10 keeps the clamped code 13 at a 1024-clock wait, which is short enough to run in full. The three-clock trigger latency from two synchronizer flops plus the edge detector is exercised in both edge-count modes and in capture.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

  typedef enum logic [1:0] {
    SRC_CLK  = 2'd0,
    SRC_RISE = 2'd1,
    SRC_FALL = 2'd2,
    SRC_EVT  = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    LV_LOW  = 2'd0,
    LV_HIGH = 2'd1,
    LV_KEEP = 2'd2,
    LV_FLIP = 2'd3
  } lvl_rule_e;

  // Level after a rule is applied; inversion only allowed for match rules.
  function automatic logic apply_rule(input lvl_rule_e r, input logic cur, input logic flip_ok);
    logic res;
    case (r)
      LV_LOW:  res = 1'b0;
      LV_HIGH: res = 1'b1;
      LV_FLIP: res = flip_ok ? ~cur : cur;
      default: res = cur;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
`timescale 1ns/1ps
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      last <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], din};
      last <= sh[STAGES-1];
    end
  end

  assign rise = sh[STAGES-1] & ~last;
  assign fall = ~sh[STAGES-1] & last;
endmodule

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int DIV_CODE_W = 4,
  parameter int MAX_CODE   = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  src_tick,
  input  logic [DIV_CODE_W-1:0] code,
  output logic                  tick
);
  localparam int PW = (MAX_CODE > 0) ? MAX_CODE : 1;

  logic [PW-1:0]         pcnt;
  logic [DIV_CODE_W-1:0] eff;
  logic [PW:0]           one_sh;
  logic [PW:0]           lim;

  always_comb begin
    eff    = (code > DIV_CODE_W'(MAX_CODE)) ? DIV_CODE_W'(MAX_CODE) : code;
    one_sh = (PW+1)'(1) << eff;
    lim    = one_sh - (PW+1)'(1);
  end

  assign tick = src_tick & ({1'b0, pcnt} >= lim);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pcnt <= '0;
    end else if (src_tick) begin
      pcnt <= tick ? '0 : pcnt + PW'(1);
    end
  end
endmodule

// File: rtl/tmr_out_level.sv
`timescale 1ns/1ps
module tmr_out_level
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic       match_ev,
  input  logic [1:0] rule_start,
  input  logic [1:0] rule_stop,
  input  logic [1:0] rule_match,
  input  logic       pwm_en,
  output logic       pwm_out
);
  logic lvl, lvl_nxt;

  always_comb begin
    if (stop_ev)
      lvl_nxt = apply_rule(lvl_rule_e'(rule_stop), lvl, 1'b0);
    else if (start_ev)
      lvl_nxt = apply_rule(lvl_rule_e'(rule_start), lvl, 1'b0);
    else if (match_ev)
      lvl_nxt = apply_rule(lvl_rule_e'(rule_match), lvl, 1'b1);
    else
      lvl_nxt = lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl     <= 1'b0;
      pwm_out <= 1'b0;
    end else begin
      lvl     <= lvl_nxt;
      pwm_out <= pwm_en & lvl_nxt;
    end
  end
endmodule

// File: rtl/pwm_timer_ch.sv
`timescale 1ns/1ps
module pwm_timer_ch
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV_CODE_W  = 4,
  parameter int MAX_CODE    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            src_sel,
  input  logic [DIV_CODE_W-1:0] div_code,
  input  logic                  capture_mode,
  input  logic [1:0]            rule_start,
  input  logic [1:0]            rule_stop,
  input  logic [1:0]            rule_match,
  input  logic                  pwm_en,
  input  logic                  start_i,
  input  logic                  stop_i,
  input  logic                  cnt_wr,
  input  logic                  cmp_wr,
  input  logic [CNT_W-1:0]      wdata,
  input  logic [1:0]            flag_clr,
  input  logic [1:0]            irq_en,
  input  logic                  trig_in,
  input  logic                  event_in,
  output logic                  running,
  output logic [CNT_W-1:0]      count,
  output logic [CNT_W-1:0]      compare,
  output logic [1:0]            flags,
  output logic                  irq,
  output logic                  pwm_out
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic trig_rise, trig_fall;
  logic src_tick, cnt_tick;
  logic match_ev, ovf_ev, cap_ev;
  logic [1:0] flag_set, flags_nxt;

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (trig_in),
    .rise (trig_rise),
    .fall (trig_fall)
  );

  always_comb begin
    case (src_e'(src_sel))
      SRC_CLK:  src_tick = 1'b1;
      SRC_RISE: src_tick = trig_rise;
      SRC_FALL: src_tick = trig_fall;
      default:  src_tick = event_in;
    endcase
  end

  tmr_prescaler #(.DIV_CODE_W(DIV_CODE_W), .MAX_CODE(MAX_CODE)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .clr      (start_i),
    .src_tick (running & src_tick & ~start_i),
    .code     (div_code),
    .tick     (cnt_tick)
  );

  always_ff @(posedge clk) begin
    if (rst)          running <= 1'b0;
    else if (stop_i)  running <= 1'b0;
    else if (start_i) running <= 1'b1;
  end

  assign match_ev = cnt_tick & ~cnt_wr & ~capture_mode & (count == compare);
  assign ovf_ev   = cnt_tick & ~cnt_wr & (count == CNT_MAX) & ~match_ev;
  assign cap_ev   = capture_mode & running & trig_rise & ~cmp_wr;

  always_ff @(posedge clk) begin
    if (rst)           count <= '0;
    else if (cnt_wr)   count <= wdata;
    else if (match_ev) count <= '0;
    else if (cnt_tick) count <= count + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)         compare <= CNT_MAX;
    else if (cmp_wr) compare <= wdata;
    else if (cap_ev) compare <= count;
  end

  assign flag_set  = {ovf_ev, match_ev | cap_ev};
  assign flags_nxt = flag_set | (flags & ~flag_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= 2'b00;
      irq   <= 1'b0;
    end else begin
      flags <= flags_nxt;
      irq   <= |(flags_nxt & irq_en);
    end
  end

  tmr_out_level u_lvl (
    .clk        (clk),
    .rst        (rst),
    .start_ev   (start_i),
    .stop_ev    (stop_i),
    .match_ev   (match_ev),
    .rule_start (rule_start),
    .rule_stop  (rule_stop),
    .rule_match (rule_match),
    .pwm_en     (pwm_en),
    .pwm_out    (pwm_out)
  );
endmodule

// File: rtl/pwm_timer_ch_chk.sv
`timescale 1ns/1ps
module pwm_timer_ch_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             pwm_en,
  input logic             stop_i,
  input logic             cnt_wr,
  input logic [1:0]       irq_en,
  input logic             running,
  input logic [CNT_W-1:0] count,
  input logic [1:0]       flags,
  input logic             irq,
  input logic             pwm_out
);
  a_r2_hold_stopped: assert property (@(posedge clk) disable iff (rst)
    (!running && !cnt_wr) |=> $stable(count));

  a_r2_stop_wins: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> !running);

  a_r3_ovf_source: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[1]) |-> ($past(count) == {CNT_W{1'b1}}));

  a_r8_output_gated: assert property (@(posedge clk) disable iff (rst)
    !pwm_en |=> !pwm_out);

  a_r10_irq_mask: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq == |(flags & $past(irq_en))));
endmodule

bind pwm_timer_ch pwm_timer_ch_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .pwm_en  (pwm_en),
  .stop_i  (stop_i),
  .cnt_wr  (cnt_wr),
  .irq_en  (irq_en),
  .running (running),
  .count   (count),
  .flags   (flags),
  .irq     (irq),
  .pwm_out (pwm_out)
);

// File: tb/tb_pwm_timer_ch.sv
`timescale 1ns/1ps
module tb_pwm_timer_ch;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  src_sel;
  logic [3:0]  div_code;
  logic        capture_mode;
  logic [1:0]  rule_start, rule_stop, rule_match;
  logic        pwm_en, start_i, stop_i, cnt_wr, cmp_wr;
  logic [15:0] wdata;
  logic [1:0]  flag_clr, irq_en;
  logic        trig_in, event_in;
  logic        running, irq, pwm_out;
  logic [15:0] count, compare;
  logic [1:0]  flags;

  int n_checks = 0;
  int n_fail   = 0;

  // reference model state
  int m_cnt, m_cmp, m_flags, m_irq, m_run, m_lvl, m_pwm, m_pcnt;
  int m_s1, m_s2, m_d;

  always #5 clk = ~clk;

  pwm_timer_ch dut (
    .clk(clk), .rst(rst), .src_sel(src_sel), .div_code(div_code),
    .capture_mode(capture_mode), .rule_start(rule_start), .rule_stop(rule_stop),
    .rule_match(rule_match), .pwm_en(pwm_en), .start_i(start_i), .stop_i(stop_i),
    .cnt_wr(cnt_wr), .cmp_wr(cmp_wr), .wdata(wdata), .flag_clr(flag_clr),
    .irq_en(irq_en), .trig_in(trig_in), .event_in(event_in), .running(running),
    .count(count), .compare(compare), .flags(flags), .irq(irq), .pwm_out(pwm_out)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int rule_apply(input int code, input int cur, input bit flip_ok);
    if (code == 0) return 0;
    if (code == 1) return 1;
    if (code == 3 && flip_ok) return 1 - cur;
    return cur;
  endfunction

  task automatic model_update();
    int rise, fall, src, lim, en, tk, mev, oev, cev, dv, setv, nflags;
    if (rst) begin
      m_cnt = 0; m_cmp = 65535; m_flags = 0; m_irq = 0; m_run = 0;
      m_lvl = 0; m_pwm = 0; m_pcnt = 0; m_s1 = 0; m_s2 = 0; m_d = 0;
      return;
    end
    rise = (m_s2 == 1 && m_d == 0) ? 1 : 0;
    fall = (m_s2 == 0 && m_d == 1) ? 1 : 0;
    case (src_sel)
      2'd0: src = 1;
      2'd1: src = rise;
      2'd2: src = fall;
      default: src = event_in ? 1 : 0;
    endcase
    dv  = (div_code > 10) ? 10 : int'(div_code);
    lim = (1 << dv) - 1;
    en  = (m_run && src && !start_i) ? 1 : 0;
    tk  = (en && m_pcnt >= lim) ? 1 : 0;
    mev = (tk && !cnt_wr && !capture_mode && m_cnt == m_cmp) ? 1 : 0;
    oev = (tk && !cnt_wr && m_cnt == 65535 && !mev) ? 1 : 0;
    cev = (capture_mode && m_run && rise && !cmp_wr) ? 1 : 0;
    // prescaler
    if (start_i) m_pcnt = 0;
    else if (en) m_pcnt = tk ? 0 : m_pcnt + 1;
    // compare register uses old counter
    if (cmp_wr) m_cmp = int'(wdata);
    else if (cev) m_cmp = m_cnt;
    // counter
    if (cnt_wr) m_cnt = int'(wdata);
    else if (mev) m_cnt = 0;
    else if (tk) m_cnt = (m_cnt + 1) % 65536;
    // flags and irq
    setv   = (oev << 1) | ((mev || cev) ? 1 : 0);
    nflags = setv | (m_flags & ~int'(flag_clr));
    m_flags = nflags;
    m_irq   = ((nflags & int'(irq_en)) != 0) ? 1 : 0;
    // level
    if (stop_i) m_lvl = rule_apply(int'(rule_stop), m_lvl, 0);
    else if (start_i) m_lvl = rule_apply(int'(rule_start), m_lvl, 0);
    else if (mev) m_lvl = rule_apply(int'(rule_match), m_lvl, 1);
    m_pwm = (pwm_en && m_lvl == 1) ? 1 : 0;
    // run state
    if (stop_i) m_run = 0;
    else if (start_i) m_run = 1;
    // trigger synchronizer history
    m_d = m_s2; m_s2 = m_s1; m_s1 = trig_in ? 1 : 0;
  endtask

  task automatic compare_all();
    chk(int'(count) == m_cnt, "R3", "count", count, m_cnt);
    chk(int'(compare) == m_cmp, "R11", "compare", compare, m_cmp);
    chk(int'(flags) == m_flags, "R9", "flags", flags, m_flags);
    chk(int'(irq) == m_irq, "R10", "irq", irq, m_irq);
    chk(int'(pwm_out) == m_pwm, "R7", "pwm_out", pwm_out, m_pwm);
    chk(int'(running) == m_run, "R2", "running", running, m_run);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic pulse_start();
    start_i = 1'b1; step(1); start_i = 1'b0;
  endtask
  task automatic pulse_stop();
    stop_i = 1'b1; step(1); stop_i = 1'b0;
  endtask
  task automatic load_cnt(input logic [15:0] v);
    cnt_wr = 1'b1; wdata = v; step(1); cnt_wr = 1'b0;
  endtask
  task automatic load_cmp(input logic [15:0] v);
    cmp_wr = 1'b1; wdata = v; step(1); cmp_wr = 1'b0;
  endtask
  task automatic clear_flags();
    flag_clr = 2'b11; step(1); flag_clr = 2'b00;
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    int c;
    logic p;
    rst = 1'b1; src_sel = 2'd0; div_code = 4'd0; capture_mode = 1'b0;
    rule_start = 2'd0; rule_stop = 2'd0; rule_match = 2'd0; pwm_en = 1'b0;
    start_i = 1'b0; stop_i = 1'b0; cnt_wr = 1'b0; cmp_wr = 1'b0; wdata = '0;
    flag_clr = 2'b00; irq_en = 2'b00; trig_in = 1'b0; event_in = 1'b0;
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk(count == 16'h0 && flags == 2'b00 && !running, "R1", "count/flags/running", {count, flags, running}, 0);
    chk(compare == 16'hFFFF && !pwm_out && !irq, "R1", "compare/pwm/irq", {compare, pwm_out, irq}, 32'hFFFF << 2);

    // R6/R7/R3: start high, toggle on match at 5
    load_cmp(16'd5);
    rule_start = 2'd1; rule_match = 2'd3; pwm_en = 1'b1;
    pulse_start();
    chk(pwm_out == 1'b1, "R6", "start high", pwm_out, 1);
    step(5);
    chk(count == 16'd5, "R3", "count before match", count, 5);
    step(1);
    chk(count == 16'd0 && flags[0], "R3", "match wrap", {count, flags}, 1);
    chk(pwm_out == 1'b0, "R7", "toggle low", pwm_out, 0);
    step(6);
    chk(pwm_out == 1'b1, "R7", "toggle high", pwm_out, 1);

    // R2/R6 stop rules and hold
    rule_stop = 2'd0;
    pulse_stop();
    chk(pwm_out == 1'b0 && !running, "R6", "stop low", {pwm_out, running}, 0);
    c = int'(count);
    step(5);
    chk(int'(count) == c, "R2", "hold while stopped", count, c);
    rule_start = 2'd2;
    pulse_start();
    chk(pwm_out == 1'b0, "R6", "start keep", pwm_out, 0);
    rule_stop = 2'd1;
    pulse_stop();
    chk(pwm_out == 1'b1, "R6", "stop high", pwm_out, 1);

    // R8 output enable
    pwm_en = 1'b0; step(1);
    chk(pwm_out == 1'b0, "R8", "disabled", pwm_out, 0);
    pwm_en = 1'b1; step(1);
    chk(pwm_out == 1'b1, "R8", "level kept", pwm_out, 1);

    // R4 prescaler
    clear_flags();
    load_cnt(16'd0);
    load_cmp(16'd1000);
    div_code = 4'd3;
    pulse_start();
    step(7);
    chk(count == 16'd0, "R4", "div8 before", count, 0);
    step(1);
    chk(count == 16'd1, "R4", "div8 first", count, 1);
    step(8);
    chk(count == 16'd2, "R4", "div8 second", count, 2);
    pulse_stop();
    load_cnt(16'd0);
    div_code = 4'd13;
    pulse_start();
    step(1023);
    chk(count == 16'd0, "R4", "clamp before", count, 0);
    step(1);
    chk(count == 16'd1, "R4", "clamp first", count, 1);

    // R5 count sources
    pulse_stop();
    div_code = 4'd0;
    load_cnt(16'd0);
    src_sel = 2'd1;
    pulse_start();
    for (int k = 0; k < 4; k++) begin
      trig_in = 1'b1; step(3); trig_in = 1'b0; step(3);
    end
    step(3);
    chk(count == 16'd4, "R5", "rising edges", count, 4);
    src_sel = 2'd2;
    load_cnt(16'd0);
    for (int k = 0; k < 4; k++) begin
      trig_in = 1'b1; step(3); trig_in = 1'b0; step(3);
    end
    step(3);
    chk(count == 16'd4, "R5", "falling edges", count, 4);
    src_sel = 2'd3;
    load_cnt(16'd0);
    for (int k = 0; k < 5; k++) begin
      event_in = 1'b1; step(1); event_in = 1'b0; step(2);
    end
    chk(count == 16'd5, "R5", "events", count, 5);

    // R3/R9/R10 overflow
    pulse_stop();
    src_sel = 2'd0;
    clear_flags();
    capture_mode = 1'b1;
    load_cnt(16'hFFFE);
    irq_en = 2'b10;
    pulse_start();
    step(1);
    chk(count == 16'hFFFF, "R3", "at max", count, 16'hFFFF);
    step(1);
    chk(count == 16'h0 && flags == 2'b10, "R3", "overflow wrap", {count, flags}, 2);
    chk(irq == 1'b1, "R10", "irq on ovf", irq, 1);
    flag_clr = 2'b10; step(1); flag_clr = 2'b00;
    chk(flags == 2'b00 && !irq, "R9", "clear ovf", {flags, irq}, 0);

    // R3 match at all ones sets only match flag
    pulse_stop();
    capture_mode = 1'b0;
    clear_flags();
    load_cmp(16'hFFFF);
    load_cnt(16'hFFFE);
    pulse_start();
    step(2);
    chk(count == 16'h0 && flags == 2'b01, "R3", "match at max", {count, flags}, 1);
    chk(irq == 1'b0, "R10", "masked match", irq, 0);

    // R11 capture
    pulse_stop();
    clear_flags();
    capture_mode = 1'b1;
    load_cnt(16'd100);
    pulse_start();
    step(2);
    p = pwm_out;
    trig_in = 1'b1;
    step(3);
    chk(compare == 16'd104 && flags[0], "R11", "capture value", {compare, flags}, (104 << 2) | 1);
    chk(pwm_out == p, "R11", "level untouched", pwm_out, p);

    // R12 load priority over counting
    capture_mode = 1'b0;
    load_cmp(16'd1000);
    load_cnt(16'd3);
    chk(count == 16'd3, "R12", "load over tick", count, 3);
    step(2);
    chk(count == 16'd5, "R12", "counting resumes", count, 5);
    pulse_stop();

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule